// File: doc/BRIEF.md
# Flash Write Strobe Qualifier

This block stands between the asynchronous memory-bus pins of a flash array and its command sequencer. A fast system clock samples the active-low chip-enable, write-enable and output-enable lines, and the address and data buses. From these samples the block forms one qualified write event per valid write strobe. That event is a single-cycle pulse that carries the captured address and data to the sequencer.

A write strobe is the interval in which chip-enable and write-enable are both low. It therefore opens when the second of the two enables falls, and the address is captured at that moment. It closes when the first of the two rises, and the data is captured at that moment. A strobe is discarded in four cases: it is narrower than a minimum number of clock samples, output-enable is low during it, the supply-good input is low, or the power-up hold-off window is still running. The hold-off window restarts every time the supply-good input goes low. That input is a digital stand-in for an analog supply detector.

All pin inputs pass through a two-stage synchronizer of equal depth, so the control lines and the buses stay aligned to the same clock sample.

Top module: `wstrobe_qual`

## Requirements
- R1: While reset is asserted and after its release, `wr_valid` is 0 and `wr_addr` and `wr_data` are all zeros until the first qualified write.
- R2: A qualified strobe produces exactly one pulse of `wr_valid`, one clock cycle long. The pulse rises at the second rising edge after the first edge that samples `ce_n` or `we_n` high.
- R3: `wr_addr` carries the address sampled at the first edge where `ce_n` and `we_n` are both sampled low, that is, the later of the two falling edges. Later changes on the address bus are ignored.
- R4: `wr_data` carries the data sampled at the last edge where `ce_n` and `we_n` are both sampled low, that is, the data in front of the first rising edge.
- R5: A strobe sampled low on fewer than `MIN_PULSE` consecutive edges gives no `wr_valid`. One sampled low on `MIN_PULSE` or more edges gives a write (default `MIN_PULSE` = 3).
- R6: If `oe_n` is sampled low at any edge during a strobe, the strobe gives no write.
- R7: Of the eight static levels of (`ce_n`, `we_n`, `oe_n`), only (0, 0, 1) gives a write.
- R8: After reset, and after `supply_ok` is sampled high again, writes stay blocked until `HOLDOFF` consecutive edges with the supply good have elapsed. A strobe that overlaps this window gives no write.
- R9: If `supply_ok` is sampled low at any edge, any strobe in progress is discarded and the R8 hold-off window starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable pin, active low, asynchronous |
| we_n | input | 1 | Write enable pin, active low, asynchronous |
| oe_n | input | 1 | Output enable pin, active low, asynchronous |
| addr | input | ADDR_W | Address bus pins |
| wdata | input | DATA_W | Data bus pins |
| supply_ok | input | 1 | High when the supply is above its threshold |
| wr_valid | output | 1 | Single-cycle qualified write event |
| wr_addr | output | ADDR_W | Captured write address, valid with `wr_valid` |
| wr_data | output | DATA_W | Captured write data, valid with `wr_data` capture rule R4 |

## Verification
The two synchronizer stages and the qualifier register place the write pulse two edges after the edge that first samples a closing enable. The bench therefore drives pins only on falling clock edges and watches six falling edges after each strobe closes. It requires the pulse on exactly the third of those edges and nowhere else. Captured address and data are read in that same cycle and compared with the bus values the bench drove at the opening and closing samples. Hold-off checks allow more than `HOLDOFF` plus the two synchronizer cycles before a write is expected to pass.

// File: rtl/wsq_pkg.sv
// Shared definitions for the write strobe qualifier.
// Assumes: nothing beyond IEEE 1800-2017.
package wsq_pkg;
    // Depth of the pin synchronizers (control and bus share it for alignment).
    localparam int SYNC_STAGES = 2;

    // Qualifier state: waiting for a strobe, or inside one.
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_STROBE = 1'b1
    } wsq_state_e;
endpackage

// File: rtl/wsq_sync.sv
// Multi-stage synchronizer for a vector of pin inputs.
// Assumes: bus inputs are stable around the sampling edge when they matter;
// all bits share one depth so that they stay aligned in time.
module wsq_sync #(
    parameter int            W       = 1,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Capture the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= d;
            end
        end else begin : g_next
            // Shift through the following stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/wsq_holdoff.sv
// Power-up hold-off timer: ready only after HOLDOFF consecutive cycles with
// the synchronized supply-good input high; any low cycle restarts it.
// Assumes: HOLDOFF >= 1.
module wsq_holdoff #(
    parameter int HOLDOFF = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_s,
    output logic ready
);
    localparam int CW = $clog2(HOLDOFF + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLDOFF);

    logic [CW-1:0] cnt;

    // Count good-supply cycles up to the limit; clear on a bad cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (!sup_s)     cnt <= '0;
        else if (cnt != LIMIT) cnt <= cnt + 1'b1;
    end

    assign ready = (cnt == LIMIT);

    AST_SUPPLY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_s |=> !ready); // R9
endmodule

// File: rtl/wsq_qualify.sv
// Strobe qualifier: tracks the interval in which both enables are low,
// captures address at its start and data at its end, and emits one
// single-cycle write event when the interval was wide enough, output-enable
// stayed high and the supply was ready throughout.
// Assumes: inputs already synchronized and mutually aligned.
module wsq_qualify
    import wsq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int MIN_PULSE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n_s,
    input  logic              we_n_s,
    input  logic              oe_n_s,
    input  logic              ready,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int CW = $clog2(MIN_PULSE + 1);
    localparam logic [CW-1:0] MINV = CW'(MIN_PULSE);

    wsq_state_e        state;
    logic [CW-1:0]     cnt;
    logic              spoiled;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              act;
    logic              bad_now;

    // Strobe active when both enables are low; inhibit on OE low or not ready.
    assign act     = !ce_n_s && !we_n_s;
    assign bad_now = !oe_n_s || !ready;

    // Strobe tracking, capture and write-event generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            spoiled  <= 1'b0;
            addr_q   <= '0;
            data_q   <= '0;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (act) begin
                        state   <= ST_STROBE;
                        cnt     <= CW'(1);
                        addr_q  <= addr_s;
                        data_q  <= data_s;
                        spoiled <= bad_now;
                    end
                end
                default: begin
                    if (act) begin
                        if (cnt != MINV) cnt <= cnt + 1'b1;
                        data_q <= data_s;
                        if (bad_now) spoiled <= 1'b1;
                    end else begin
                        state   <= ST_IDLE;
                        cnt     <= '0;
                        spoiled <= 1'b0;
                        if (!spoiled && cnt >= MINV) begin
                            wr_valid <= 1'b1;
                            wr_addr  <= addr_q;
                            wr_data  <= data_q;
                        end
                    end
                end
            endcase
        end
    end

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid); // R2
    AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ($past(cnt) >= MINV)); // R5
    AST_OE_HIGH_AT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(oe_n_s, 2)); // R6
    AST_READY_AT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(ready, 2)); // R8
endmodule

// File: rtl/wstrobe_qual.sv
// Top of the write strobe qualifier: synchronizes the bus pins and the
// supply-good input, runs the hold-off timer and the strobe qualifier.
// Assumes: pin inputs are asynchronous to clk; the clock is fast enough that
// MIN_PULSE cycles span the shortest glitch to be rejected.
module wstrobe_qual
    import wsq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int MIN_PULSE = 3,
    parameter int HOLDOFF   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              supply_ok,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int BW = ADDR_W + DATA_W;

    logic [2:0]    ctl_s;
    logic          sup_s;
    logic [BW-1:0] bus_s;
    logic          ready;

    wsq_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n), .d({ce_n, we_n, oe_n}), .q(ctl_s)
    );

    wsq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sup (
        .clk(clk), .rst_n(rst_n), .d(supply_ok), .q(sup_s)
    );

    wsq_sync #(.W(BW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
        .clk(clk), .rst_n(rst_n), .d({addr, wdata}), .q(bus_s)
    );

    wsq_holdoff #(.HOLDOFF(HOLDOFF)) u_holdoff (
        .clk(clk), .rst_n(rst_n), .sup_s(sup_s), .ready(ready)
    );

    wsq_qualify #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)) u_qual (
        .clk(clk), .rst_n(rst_n),
        .ce_n_s(ctl_s[2]), .we_n_s(ctl_s[1]), .oe_n_s(ctl_s[0]),
        .ready(ready),
        .addr_s(bus_s[BW-1:DATA_W]), .data_s(bus_s[DATA_W-1:0]),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !wr_valid); // R1
endmodule

// File: tb/wstrobe_qual_tb.sv
module wstrobe_qual_tb;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int MINP = 3;
    localparam int HOLD = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic supply_ok = 1'b1;
    logic wr_valid;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int got_n, got_idx;
    logic [AW-1:0] got_a;
    logic [DW-1:0] got_d;

    always #4 clk = ~clk; // 125 MHz

    wstrobe_qual #(.ADDR_W(AW), .DATA_W(DW), .MIN_PULSE(MINP), .HOLDOFF(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .supply_ok(supply_ok),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Watch six falling edges for write events.
    task automatic observe();
        got_n = 0; got_idx = 0; got_a = '0; got_d = '0;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (wr_valid) begin
                got_n++; got_idx = i; got_a = wr_addr; got_d = wr_data;
            end
        end
    endtask

    // Plain strobe: both enables low for n cycles, then released and observed.
    task automatic pulse(input int n, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic oe);
        @(negedge clk);
        addr = a; wdata = d; oe_n = oe; ce_n = 1'b0; we_n = 1'b0;
        repeat (n) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        observe();
    endtask

    task automatic expect_write(input string req, input logic [AW-1:0] a, input logic [DW-1:0] d);
        check(got_n == 1, req, got_n, 1);
        check(got_idx == 3, req, got_idx, 3);
        check(got_a == a, req, int'(got_a), int'(a));
        check(got_d == d, req, int'(got_d), int'(d));
    endtask

    // Staggered enables: first falls, second falls later; second rises first.
    task automatic stagger(input bit ce_first, input string req);
        @(negedge clk);
        addr = 8'hA0; wdata = 8'h00;
        if (ce_first) ce_n = 1'b0; else we_n = 1'b0;
        repeat (2) @(negedge clk);
        addr = 8'hA1; wdata = 8'hD0;
        if (ce_first) we_n = 1'b0; else ce_n = 1'b0;
        repeat (2) @(negedge clk);
        addr = 8'hA2; wdata = 8'hD1;
        repeat (2) @(negedge clk);
        addr = 8'hA3;
        if (ce_first) we_n = 1'b1; else ce_n = 1'b1;
        @(negedge clk);
        wdata = 8'hD2;
        ce_n = 1'b1; we_n = 1'b1;
        observe();
        check(got_n == 1, req, got_n, 1);
        check(got_idx == 2, req, got_idx, 2);
        check(got_a == 8'hA1, {req, " R3"}, int'(got_a), 'hA1);
        check(got_d == 8'hD1, {req, " R4"}, int'(got_d), 'hD1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(wr_valid == 1'b0, "R1 valid in reset", wr_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(wr_valid == 1'b0, "R1 valid", wr_valid, 0);
        check(wr_addr == '0, "R1 addr", int'(wr_addr), 0);
        check(wr_data == '0, "R1 data", int'(wr_data), 0);

        // R8: strobe inside the hold-off window after reset is dropped
        pulse(5, 8'h11, 8'h22, 1'b1);
        check(got_n == 0, "R8 early write", got_n, 0);
        repeat (HOLD + 8) @(negedge clk);

        // R5, R2: width sweep
        for (int n = 1; n <= MINP + 3; n++) begin
            logic [AW-1:0] a;
            a = AW'(8'h10 + n);
            pulse(n, a, ~a, 1'b1);
            if (n < MINP) check(got_n == 0, "R5 narrow strobe", got_n, 0);
            else          expect_write("R5 R2 wide strobe", a, ~a);
        end

        // R7: all static control levels
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            addr = AW'(8'h40 + c); wdata = DW'(8'h80 + c);
            ce_n = c[2]; we_n = c[1]; oe_n = c[0];
            repeat (6) @(negedge clk);
            ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
            observe();
            if (c == 1) check(got_n == 1, "R7 ce0 we0 oe1 writes", got_n, 1);
            else        check(got_n == 0, "R7 inhibited level", got_n, 0);
        end

        // R3, R4: later falling edge and first rising edge, both orders
        stagger(1'b1, "R3 R4 ce first");
        stagger(1'b0, "R3 R4 we first");

        // R6: output enable low for one cycle mid-strobe
        @(negedge clk);
        addr = 8'h55; wdata = 8'h66; ce_n = 1'b0; we_n = 1'b0;
        repeat (2) @(negedge clk);
        oe_n = 1'b0;
        @(negedge clk);
        oe_n = 1'b1;
        repeat (2) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        observe();
        check(got_n == 0, "R6 oe low mid strobe", got_n, 0);

        // R2: back-to-back strobes give one event each
        pulse(4, 8'h71, 8'h72, 1'b1);
        expect_write("R2 first of pair", 8'h71, 8'h72);
        pulse(4, 8'h73, 8'h74, 1'b1);
        expect_write("R2 second of pair", 8'h73, 8'h74);

        // R9: supply drop during a strobe
        @(negedge clk);
        addr = 8'h90; wdata = 8'h91; ce_n = 1'b0; we_n = 1'b0;
        repeat (2) @(negedge clk);
        supply_ok = 1'b0;
        repeat (2) @(negedge clk);
        supply_ok = 1'b1;
        repeat (2) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        observe();
        check(got_n == 0, "R9 supply drop", got_n, 0);
        // R9/R8: hold-off restarted after the drop
        pulse(5, 8'h92, 8'h93, 1'b1);
        check(got_n == 0, "R9 hold-off restarted", got_n, 0);
        repeat (HOLD + 8) @(negedge clk);
        pulse(5, 8'h94, 8'h95, 1'b1);
        expect_write("R8 after hold-off", 8'h94, 8'h95);

        // R9: supply held low blocks writes
        supply_ok = 1'b0;
        repeat (3) @(negedge clk);
        pulse(5, 8'h96, 8'h97, 1'b1);
        check(got_n == 0, "R9 supply low", got_n, 0);
        supply_ok = 1'b1;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule